// File: doc/BRIEF.md
# Register Execution Unit with Flag Register

This block is the integer execution slice of a small byte-oriented processor. It holds sixteen 8-bit general registers, the last of which also acts as the flag register. Each cycle in which the valid strobe is high, it executes one operation chosen by a 4-bit opcode class and, for the register-to-register class, a 4-bit sub-opcode. Operands come from the registers named by the X and Y indices or from an 8-bit immediate. The result is always written back into register X.

The unit also evaluates the conditional-skip tests of the instruction set and reports the outcome on a skip output. The sequencer that fetches instructions and steps the program counter uses that output. Any combination of class and sub-opcode that the unit does not know is reported on an illegal output and leaves every register as it was. Two combinational read ports give the surrounding logic access to any register at any time.

Top module: `reg_exec_unit`

## Requirements
- R1: After a synchronous active-low reset, all sixteen registers read 0 and both `skip_next` and `op_illegal` are 0.
- R2: Class 4'h8 with sub-opcode 0, 1, 2 or 3 writes Y, X|Y, X&Y or X^Y into register X, and register 15 is changed only when it is X itself.
- R3: Class 4'h8 with sub-opcode 4 writes the low 8 bits of X+Y into X and sets register 15 to 1 when the 9-bit sum exceeds 255, otherwise 0.
- R4: Class 4'h8 with sub-opcode 5 writes (X-Y) mod 256 into X and sets register 15 to 1 when X >= Y, otherwise 0.
- R5: Class 4'h7 adds the immediate to X modulo 256 and leaves register 15 unchanged unless register 15 is itself X.
- R6: Class 4'h6 loads the immediate into register X.
- R7: Class 4'h3 raises `skip_next` when X equals the immediate, and class 4'h4 raises it when they differ. In both classes the sub-opcode is ignored, and no register changes.
- R8: Class 4'h5 raises `skip_next` when X equals Y, and class 4'h9 raises it when they differ. In both classes the sub-opcode must be 0, and no register changes.
- R9: Class 4'h8 with sub-opcode 6 to 15, class 4'h5 or 4'h9 with a non-zero sub-opcode, and classes 4'h0-4'h2 and 4'hA-4'hF raise `op_illegal`. Such an operation changes no register and leaves `skip_next` low.
- R10: When X is register 15 on an add or subtract, register 15 ends up holding the flag, not the arithmetic result.
- R11: Every operation takes effect at the clock edge that samples the valid strobe. `skip_next` and `op_illegal` are high only in the cycle after that edge. A cycle without the strobe changes nothing and leaves both outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Execute the operation presented this cycle |
| op_class | input | 4 | Opcode class |
| op_sub | input | 4 | Sub-opcode, used by classes 4'h5, 4'h8 and 4'h9 |
| idx_x | input | 4 | Destination and first operand register index |
| idx_y | input | 4 | Second operand register index |
| imm | input | 8 | Immediate operand |
| rd_sel_a | input | 4 | Read port A register index |
| rd_data_a | output | 8 | Read port A data (combinational) |
| rd_sel_b | input | 4 | Read port B register index |
| rd_data_b | output | 8 | Read port B data (combinational) |
| skip_next | output | 1 | Skip condition was true for the previous operation |
| op_illegal | output | 1 | Previous operation was not recognised |

## Verification
The bench builds the unit with its default parameters: 8-bit data and sixteen registers, so the flag is register 15. With this width, directed operands reach the exact carry and borrow limits (255+1, 200+100, equal subtraction). They also cover operations whose X or Y is register 15 itself. After every operation, a random stream over all sixteen classes and sub-opcodes compares the whole register file through both read ports against a behavioural model. That stream includes the illegal codes and the sub-opcodes that the immediate classes ignore.

// File: rtl/reg_exec_pkg.sv
// Shared encodings for the register execution unit.
// Assumes a 4-bit opcode class and a 4-bit sub-opcode field.
package reg_exec_pkg;

    // Opcode classes recognised by the unit (others are illegal).
    typedef enum logic [3:0] {
        CLS_SKIP_EQ_IMM = 4'h3,
        CLS_SKIP_NE_IMM = 4'h4,
        CLS_SKIP_EQ_REG = 4'h5,
        CLS_LOAD_IMM    = 4'h6,
        CLS_ADD_IMM     = 4'h7,
        CLS_REG_ALU     = 4'h8,
        CLS_SKIP_NE_REG = 4'h9
    } op_class_e;

    // Sub-opcodes of the register-to-register class.
    typedef enum logic [3:0] {
        SUB_MOVE = 4'h0,
        SUB_OR   = 4'h1,
        SUB_AND  = 4'h2,
        SUB_XOR  = 4'h3,
        SUB_ADD  = 4'h4,
        SUB_SUB  = 4'h5
    } alu_sub_e;

    // Result source chosen by the decoder.
    typedef enum logic [2:0] {
        RES_COPY_Y,
        RES_OR,
        RES_AND,
        RES_XOR,
        RES_ADD,
        RES_SUB,
        RES_IMM,
        RES_ADD_IMM
    } res_sel_e;

    // Decoded control for one operation.
    typedef struct packed {
        logic     legal;
        logic     wr_x;
        logic     wr_flag;
        logic     cmp_en;
        logic     cmp_imm;
        logic     cmp_ne;
        res_sel_e res_sel;
    } dec_ctrl_t;

endpackage

// File: rtl/reg_exec_decode.sv
// Operation decoder: maps class and sub-opcode onto write, flag and
// compare controls. Purely combinational; assumes the caller gates the
// result with the valid strobe.
module reg_exec_decode
    import reg_exec_pkg::*;
(
    input  logic [3:0] op_class,
    input  logic [3:0] op_sub,
    output dec_ctrl_t  ctrl
);

    // Decode one operation; default is an illegal, side-effect-free op.
    always_comb begin
        ctrl         = '0;
        ctrl.res_sel = RES_COPY_Y;
        case (op_class)
            CLS_SKIP_EQ_IMM: begin
                ctrl.legal   = 1'b1;
                ctrl.cmp_en  = 1'b1;
                ctrl.cmp_imm = 1'b1;
            end
            CLS_SKIP_NE_IMM: begin
                ctrl.legal   = 1'b1;
                ctrl.cmp_en  = 1'b1;
                ctrl.cmp_imm = 1'b1;
                ctrl.cmp_ne  = 1'b1;
            end
            CLS_SKIP_EQ_REG: begin
                ctrl.legal  = (op_sub == 4'h0);
                ctrl.cmp_en = (op_sub == 4'h0);
            end
            CLS_SKIP_NE_REG: begin
                ctrl.legal  = (op_sub == 4'h0);
                ctrl.cmp_en = (op_sub == 4'h0);
                ctrl.cmp_ne = 1'b1;
            end
            CLS_LOAD_IMM: begin
                ctrl.legal   = 1'b1;
                ctrl.wr_x    = 1'b1;
                ctrl.res_sel = RES_IMM;
            end
            CLS_ADD_IMM: begin
                ctrl.legal   = 1'b1;
                ctrl.wr_x    = 1'b1;
                ctrl.res_sel = RES_ADD_IMM;
            end
            CLS_REG_ALU: begin
                ctrl.legal = 1'b1;
                ctrl.wr_x  = 1'b1;
                case (op_sub)
                    SUB_MOVE: ctrl.res_sel = RES_COPY_Y;
                    SUB_OR:   ctrl.res_sel = RES_OR;
                    SUB_AND:  ctrl.res_sel = RES_AND;
                    SUB_XOR:  ctrl.res_sel = RES_XOR;
                    SUB_ADD: begin
                        ctrl.res_sel = RES_ADD;
                        ctrl.wr_flag = 1'b1;
                    end
                    SUB_SUB: begin
                        ctrl.res_sel = RES_SUB;
                        ctrl.wr_flag = 1'b1;
                    end
                    default: begin
                        ctrl.legal = 1'b0;
                        ctrl.wr_x  = 1'b0;
                    end
                endcase
            end
            default: ctrl = '0;
        endcase
    end

endmodule

// File: rtl/reg_exec_datapath.sv
// Arithmetic and logic datapath: forms the write-back value and the flag
// bit. Combinational; assumes operands are already read from the file.
module reg_exec_datapath
    import reg_exec_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] x_val,
    input  logic [DATA_W-1:0] y_val,
    input  logic [DATA_W-1:0] imm,
    input  res_sel_e          res_sel,
    output logic [DATA_W-1:0] result,
    output logic              flag_bit
);

    logic [DATA_W:0] sum_wide;
    logic [DATA_W:0] diff_wide;

    // Widened add and subtract expose carry and borrow in the top bit.
    always_comb begin
        sum_wide  = {1'b0, x_val} + {1'b0, y_val};
        diff_wide = {1'b0, x_val} - {1'b0, y_val};
    end

    // Select the write-back value and the flag for the current operation.
    always_comb begin
        flag_bit = 1'b0;
        case (res_sel)
            RES_COPY_Y:  result = y_val;
            RES_OR:      result = x_val | y_val;
            RES_AND:     result = x_val & y_val;
            RES_XOR:     result = x_val ^ y_val;
            RES_ADD: begin
                result   = sum_wide[DATA_W-1:0];
                flag_bit = sum_wide[DATA_W];
            end
            RES_SUB: begin
                result   = diff_wide[DATA_W-1:0];
                flag_bit = ~diff_wide[DATA_W];
            end
            RES_IMM:     result = imm;
            RES_ADD_IMM: result = x_val + imm;
            default:     result = y_val;
        endcase
    end

endmodule

// File: rtl/reg_exec_skip.sv
// Skip-condition evaluator: compares X with Y or with the immediate and
// applies the requested polarity. Combinational.
module reg_exec_skip #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] x_val,
    input  logic [DATA_W-1:0] y_val,
    input  logic [DATA_W-1:0] imm,
    input  logic              cmp_imm,
    input  logic              cmp_ne,
    output logic              cond_true
);

    logic [DATA_W-1:0] rhs;

    // Pick the comparison operand and evaluate equality with polarity.
    always_comb begin
        rhs       = cmp_imm ? imm : y_val;
        cond_true = (x_val == rhs) ^ cmp_ne;
    end

endmodule

// File: rtl/reg_exec_regfile.sv
// Register file with one data write port, one flag write port and
// RD_PORTS combinational read ports. The flag port has priority on the
// flag register so that a flag write overrides a data write to it.
// Assumes NUM_REGS is a power of two.
module reg_exec_regfile #(
    parameter int DATA_W   = 8,
    parameter int NUM_REGS = 16,
    parameter int RD_PORTS = 4,
    localparam int IDX_W   = $clog2(NUM_REGS),
    localparam int FLAG_IDX = NUM_REGS - 1
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr_en,
    input  logic [IDX_W-1:0]                    wr_idx,
    input  logic [DATA_W-1:0]                   wr_data,
    input  logic                                flag_en,
    input  logic                                flag_data,
    input  logic [RD_PORTS-1:0][IDX_W-1:0]      rd_idx,
    output logic [RD_PORTS-1:0][DATA_W-1:0]     rd_data,
    output logic [NUM_REGS-1:0][DATA_W-1:0]     regs_view
);

    logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        if (g == FLAG_IDX) begin : g_flag
            // Flag register: flag write wins over a data write.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    regs_q[g] <= '0;
                else if (flag_en)
                    regs_q[g] <= {{(DATA_W-1){1'b0}}, flag_data};
                else if (wr_en && wr_idx == IDX_W'(g))
                    regs_q[g] <= wr_data;
            end
        end else begin : g_gpr
            // General register: plain write-enable storage.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    regs_q[g] <= '0;
                else if (wr_en && wr_idx == IDX_W'(g))
                    regs_q[g] <= wr_data;
            end
        end
    end

    for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
        assign rd_data[p] = regs_q[rd_idx[p]];
    end

    assign regs_view = regs_q;

    AST_FLAG_IS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        flag_en |=> (regs_q[FLAG_IDX] <= DATA_W'(1))) else $error("flag not 0/1"); // R3

endmodule

// File: rtl/reg_exec_unit.sv
// Top of the register execution unit. Decodes the operation, reads X and
// Y, computes the write-back value and flag, and registers the skip and
// illegal indications for one cycle. Assumes op_* inputs are stable
// around the clock edge at which op_valid is sampled.
module reg_exec_unit
    import reg_exec_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int NUM_REGS = 16,
    localparam int IDX_W   = $clog2(NUM_REGS),
    localparam int FLAG_IDX = NUM_REGS - 1,
    localparam int RD_PORTS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [3:0]        op_class,
    input  logic [3:0]        op_sub,
    input  logic [IDX_W-1:0]  idx_x,
    input  logic [IDX_W-1:0]  idx_y,
    input  logic [DATA_W-1:0] imm,
    input  logic [IDX_W-1:0]  rd_sel_a,
    output logic [DATA_W-1:0] rd_data_a,
    input  logic [IDX_W-1:0]  rd_sel_b,
    output logic [DATA_W-1:0] rd_data_b,
    output logic              skip_next,
    output logic              op_illegal
);

    dec_ctrl_t                          ctrl;
    logic [RD_PORTS-1:0][IDX_W-1:0]     rd_idx;
    logic [RD_PORTS-1:0][DATA_W-1:0]    rd_data;
    logic [NUM_REGS-1:0][DATA_W-1:0]    regs_view;
    logic [DATA_W-1:0]                  x_val;
    logic [DATA_W-1:0]                  y_val;
    logic [DATA_W-1:0]                  result;
    logic                               flag_bit;
    logic                               cond_true;
    logic                               skip_q;
    logic                               illegal_q;

    assign rd_idx    = {idx_y, idx_x, rd_sel_b, rd_sel_a};
    assign rd_data_a = rd_data[0];
    assign rd_data_b = rd_data[1];
    assign x_val     = rd_data[2];
    assign y_val     = rd_data[3];

    reg_exec_decode u_decode (
        .op_class (op_class),
        .op_sub   (op_sub),
        .ctrl     (ctrl)
    );

    reg_exec_datapath #(.DATA_W(DATA_W)) u_datapath (
        .x_val    (x_val),
        .y_val    (y_val),
        .imm      (imm),
        .res_sel  (ctrl.res_sel),
        .result   (result),
        .flag_bit (flag_bit)
    );

    reg_exec_skip #(.DATA_W(DATA_W)) u_skip (
        .x_val     (x_val),
        .y_val     (y_val),
        .imm       (imm),
        .cmp_imm   (ctrl.cmp_imm),
        .cmp_ne    (ctrl.cmp_ne),
        .cond_true (cond_true)
    );

    reg_exec_regfile #(
        .DATA_W   (DATA_W),
        .NUM_REGS (NUM_REGS),
        .RD_PORTS (RD_PORTS)
    ) u_regfile (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (op_valid && ctrl.legal && ctrl.wr_x),
        .wr_idx    (idx_x),
        .wr_data   (result),
        .flag_en   (op_valid && ctrl.legal && ctrl.wr_flag),
        .flag_data (flag_bit),
        .rd_idx    (rd_idx),
        .rd_data   (rd_data),
        .regs_view (regs_view)
    );

    // Register the one-cycle skip and illegal indications.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            skip_q    <= 1'b0;
            illegal_q <= 1'b0;
        end else begin
            skip_q    <= op_valid && ctrl.legal && ctrl.cmp_en && cond_true;
            illegal_q <= op_valid && !ctrl.legal;
        end
    end

    assign skip_next  = skip_q;
    assign op_illegal = illegal_q;

    AST_ADD_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_class == CLS_REG_ALU && op_sub == SUB_ADD)
        |=> regs_view[FLAG_IDX] == DATA_W'((({1'b0, $past(x_val)} + {1'b0, $past(y_val)}) >> DATA_W)))
        else $error("add flag"); // R3

    AST_SUB_NO_BORROW: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_class == CLS_REG_ALU && op_sub == SUB_SUB)
        |=> regs_view[FLAG_IDX] == DATA_W'($past(x_val) >= $past(y_val)))
        else $error("sub flag"); // R4

    AST_ADD_IMM_FLAG_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_class == CLS_ADD_IMM && idx_x != IDX_W'(FLAG_IDX))
        |=> $stable(regs_view[FLAG_IDX])) else $error("addi touched flag"); // R5

    AST_ILLEGAL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !ctrl.legal) |=> ($stable(regs_view) && op_illegal && !skip_next))
        else $error("illegal op changed state"); // R9

    AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> ($stable(regs_view) && !skip_next && !op_illegal))
        else $error("idle cycle changed state"); // R11

    AST_SKIP_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        skip_next |-> ($past(op_valid) && !op_illegal)) else $error("stray skip"); // R7

endmodule

// File: tb/test_reg_exec_unit.sv
// Self-checking bench: a behavioural model of the sixteen registers is
// updated per operation and compared against both read ports, skip_next
// and op_illegal after every clock.
module test_reg_exec_unit;

    localparam int CLK_PERIOD = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [3:0] op_class = '0;
    logic [3:0] op_sub = '0;
    logic [3:0] idx_x = '0;
    logic [3:0] idx_y = '0;
    logic [7:0] imm = '0;
    logic [3:0] rd_sel_a = '0;
    logic [3:0] rd_sel_b = '0;
    logic [7:0] rd_data_a;
    logic [7:0] rd_data_b;
    logic       skip_next;
    logic       op_illegal;

    int checks = 0;
    int errors = 0;
    int model[16];
    bit exp_skip;
    bit exp_ill;

    always #(CLK_PERIOD/2) clk = ~clk;

    reg_exec_unit i_reg_exec_unit (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_valid   (op_valid),
        .op_class   (op_class),
        .op_sub     (op_sub),
        .idx_x      (idx_x),
        .idx_y      (idx_y),
        .imm        (imm),
        .rd_sel_a   (rd_sel_a),
        .rd_data_a  (rd_data_a),
        .rd_sel_b   (rd_sel_b),
        .rd_data_b  (rd_data_b),
        .skip_next  (skip_next),
        .op_illegal (op_illegal)
    );

    task automatic check(input int act, input int exp, input string tag, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Behavioural model of one operation.
    task automatic model_op(input int cls, input int sub, input int x, input int y, input int im);
        int a = model[x];
        int b = model[y];
        exp_skip = 0;
        exp_ill  = 0;
        case (cls)
            3: exp_skip = (a == im);
            4: exp_skip = (a != im);
            5: if (sub == 0) exp_skip = (a == b); else exp_ill = 1;
            9: if (sub == 0) exp_skip = (a != b); else exp_ill = 1;
            6: model[x] = im;
            7: model[x] = (a + im) % 256;
            8: case (sub)
                0: model[x] = b;
                1: model[x] = a | b;
                2: model[x] = a & b;
                3: model[x] = a ^ b;
                4: begin model[x] = (a + b) % 256; model[15] = (a + b > 255) ? 1 : 0; end
                5: begin model[x] = (a - b + 256) % 256; model[15] = (a >= b) ? 1 : 0; end
                default: exp_ill = 1;
            endcase
            default: exp_ill = 1;
        endcase
    endtask

    // Compare outputs and sweep every register through both read ports.
    task automatic compare_all(input string tag);
        check(int'(skip_next), int'(exp_skip), tag, "skip_next");
        check(int'(op_illegal), int'(exp_ill), tag, "op_illegal");
        for (int r = 0; r < 16; r++) begin
            rd_sel_a = 4'(r);
            rd_sel_b = 4'(15 - r);
            #1;
            check(int'(rd_data_a), model[r], tag, $sformatf("reg%0d port A", r));
            check(int'(rd_data_b), model[15 - r], tag, $sformatf("reg%0d port B", 15 - r));
        end
    endtask

    task automatic run_op(input int cls, input int sub, input int x, input int y, input int im,
                          input string tag);
        op_class = 4'(cls);
        op_sub   = 4'(sub);
        idx_x    = 4'(x);
        idx_y    = 4'(y);
        imm      = 8'(im);
        op_valid = 1'b1;
        model_op(cls, sub, x, y, im);
        @(posedge clk);
        #1;
        op_valid = 1'b0;
        compare_all(tag);
    endtask

    task automatic run_idle(input string tag);
        op_class = 4'h8;
        op_sub   = 4'h4;
        idx_x    = 4'd15;
        idx_y    = 4'd3;
        imm      = 8'hA5;
        op_valid = 1'b0;
        exp_skip = 0;
        exp_ill  = 0;
        @(posedge clk);
        #1;
        compare_all(tag);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int r = 0; r < 16; r++) model[r] = 0;
        exp_skip = 0;
        exp_ill  = 0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        compare_all("R1");

        // Loads
        for (int r = 0; r < 16; r++) run_op(6, r, r, 0, 16 * r + 3, "R6");
        // Logic ops and move
        run_op(8, 1, 1, 2, 0, "R2");
        run_op(8, 2, 3, 4, 0, "R2");
        run_op(8, 3, 5, 6, 0, "R2");
        run_op(8, 0, 7, 8, 0, "R2");
        run_op(8, 3, 9, 9, 0, "R2");
        // Add carry boundaries
        run_op(6, 0, 1, 0, 200, "R6");
        run_op(6, 0, 2, 0, 100, "R6");
        run_op(8, 4, 1, 2, 0, "R3");
        run_op(6, 0, 1, 0, 255, "R6");
        run_op(6, 0, 2, 0, 1, "R6");
        run_op(8, 4, 1, 2, 0, "R3");
        run_op(6, 0, 1, 0, 100, "R6");
        run_op(6, 0, 2, 0, 100, "R6");
        run_op(8, 4, 1, 2, 0, "R3");
        // Subtract borrow boundaries
        run_op(6, 0, 3, 0, 5, "R6");
        run_op(6, 0, 4, 0, 7, "R6");
        run_op(8, 5, 3, 4, 0, "R4");
        run_op(6, 0, 3, 0, 7, "R6");
        run_op(8, 5, 3, 4, 0, "R4");
        run_op(8, 5, 4, 2, 0, "R4");
        // Immediate add keeps the flag, wraps
        run_op(8, 5, 3, 3, 0, "R4");
        run_op(6, 0, 5, 0, 250, "R6");
        run_op(7, 9, 5, 0, 10, "R5");
        run_op(7, 0, 15, 0, 3, "R5");
        // Flag register as destination
        run_op(6, 0, 15, 0, 250, "R10");
        run_op(6, 0, 6, 0, 10, "R10");
        run_op(8, 4, 15, 6, 0, "R10");
        run_op(6, 0, 15, 0, 3, "R10");
        run_op(8, 5, 15, 6, 0, "R10");
        run_op(8, 1, 15, 6, 0, "R2");
        // Immediate compares
        run_op(6, 0, 8, 0, 66, "R6");
        run_op(3, 7, 8, 0, 66, "R7");
        run_op(3, 0, 8, 0, 67, "R7");
        run_op(4, 0, 8, 0, 67, "R7");
        run_op(4, 11, 8, 0, 66, "R7");
        run_idle("R11");
        // Register compares
        run_op(6, 0, 9, 0, 66, "R6");
        run_op(5, 0, 8, 9, 0, "R8");
        run_op(9, 0, 8, 9, 0, "R8");
        run_op(9, 0, 8, 10, 0, "R8");
        run_op(5, 0, 8, 10, 0, "R8");
        // Illegal encodings
        run_op(5, 1, 8, 9, 0, "R9");
        run_op(9, 15, 8, 10, 0, "R9");
        for (int s = 6; s < 16; s++) run_op(8, s, 1, 2, 0, "R9");
        run_op(0, 0, 1, 2, 9, "R9");
        run_op(2, 0, 1, 2, 9, "R9");
        run_op(10, 0, 1, 2, 9, "R9");
        run_op(15, 5, 1, 2, 9, "R9");
        run_idle("R11");
        run_idle("R11");

        // Random stream over every class and sub-opcode
        for (int i = 0; i < 400; i++) begin
            int c = int'($urandom_range(0, 15));
            int s = int'($urandom_range(0, 15));
            if (($urandom_range(0, 3) != 0) && c == 8) s = s % 6;
            if (($urandom_range(0, 1) != 0) && (c == 5 || c == 9)) s = 0;
            if (i % 37 == 0) run_idle("R11");
            run_op(c, s, int'($urandom_range(0, 15)), int'($urandom_range(0, 15)),
                   int'($urandom_range(0, 255)), "R2");
        end

        // Reset again mid-run
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        for (int r = 0; r < 16; r++) model[r] = 0;
        exp_skip = 0;
        exp_ill  = 0;
        compare_all("R1");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule